// File: doc/BRIEF.md
# Terminal Count Delay Timer

The block counts down a programmed number of count strobes and then raises a done flag. It serves as a delay or timeout source. The count clock is a single-cycle enable strobe, `tick_i`, sampled on the rising edge of `clk`. That strobe can come from any tick source, such as the output of another timer. A CPU writes the 16-bit start value as two bytes through a byte-wide write port. The counter can be frozen into a readback copy with a latch command, and that copy is read out one byte at a time through the same narrow interface.

A four-state load machine controls the block:

- `LD_EMPTY`: no count has been loaded since reset.
- `LD_HALF`: the low byte has been written and the high byte is awaited.
- `LD_PEND`: a full value is stored and waits for the next strobe.
- `LD_RUN`: the counter is counting.

The transitions are:

- EMPTY→HALF, PEND→HALF and RUN→HALF on any byte write.
- HALF→PEND on the second byte write.
- PEND→RUN on a strobe with no write in the same cycle.

A write always takes priority over a strobe in the same cycle.

Top module: `dlyt_top`

## Requirements
- R1: After reset `done_o` is 0, the readback value is 0, and `done_o` stays 0 until a complete two-byte count has been loaded and has run out.
- R2: Count bytes are written low byte first, then high byte. On the first strobe after the high byte, the 16-bit value is copied into the counter. That strobe does not decrement.
- R3: Each strobe after the copy decrements the counter by 1. For a loaded value N ≥ 1, `done_o` rises on the strobe that brings the counter to 0, which is N+1 strobes after the load.
- R4: After `done_o` rises, later strobes keep decrementing the counter, wrapping from 0 to 0xFFFF, and `done_o` stays 1.
- R5: Writing a new count before expiry aborts the old count and clears `done_o`. The new value is copied on the first strobe after its high byte, and counting restarts from it.
- R6: Between the low-byte and high-byte writes the counter does not change on strobes, and `done_o` is 0.
- R7: Strobes that arrive while no complete count has ever been loaded are ignored, and the counter stays 0.
- R8: A loaded value of 0 makes `done_o` rise 0xFFFF + 2 = 65537 strobes after the load.
- R9: A `latch_i` pulse freezes a copy of the counter without disturbing counting. Reads return the copy, low byte on the first read and high byte on the second. The second read releases the copy, so reads follow the live counter again. A latch pulse while a copy is held is ignored.
- R10: A strobe in the same cycle as a byte write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count strobe, one count per cycle high |
| wr_i | input | 1 | Byte write of the count value |
| wr_data_i | input | 8 | Count byte (low first, then high) |
| latch_i | input | 1 | Freeze a readback copy of the counter |
| rd_i | input | 1 | Read one readback byte; advances low/high pointer |
| rd_data_o | output | 8 | Readback byte selected by the pointer |
| done_o | output | 1 | High once the count has run out |

## Verification
The hardest situation to reach from the ports is a count of zero. It needs 65537 strobes before the flag rises. The stimulus holds `tick_i` high for 65536 cycles, checks that the flag is still low, and then gives one more strobe. The frozen half-loaded state and a write that collides with a strobe are also hard to reach. For both, the stimulus writes a single byte in the middle of a run, keeps strobing, and reads the counter back through the byte port to show that it has not moved.

// File: rtl/dlyt_pkg.sv
package dlyt_pkg;
    typedef enum logic [1:0] {
        LD_EMPTY = 2'd0,
        LD_HALF  = 2'd1,
        LD_PEND  = 2'd2,
        LD_RUN   = 2'd3
    } ld_state_t;
endpackage

// File: rtl/dlyt_load_fsm.sv
module dlyt_load_fsm
    import dlyt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              tick_i,
    output logic [CNT_W-1:0]  start_val_o,
    output logic              copy_o,
    output logic              dec_o,
    output logic              clr_o,
    output logic              armed_o
);
    ld_state_t state_q, state_d;
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic tick_ok;

    assign tick_ok = tick_i & ~wr_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_EMPTY: if (wr_i) state_d = LD_HALF;
            LD_HALF:  if (wr_i) state_d = LD_PEND;
            LD_PEND: begin
                if (wr_i)         state_d = LD_HALF;
                else if (tick_ok) state_d = LD_RUN;
            end
            LD_RUN:   if (wr_i) state_d = LD_HALF;
            default:  state_d = LD_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_EMPTY;
        else        state_q <= state_d;
    end

    // staging bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_i) begin
            if (state_q == LD_HALF) hi_q <= wr_data_i;
            else                    lo_q <= wr_data_i;
        end
    end

    // outputs
    always_comb begin
        copy_o  = 1'b0;
        dec_o   = 1'b0;
        armed_o = 1'b0;
        unique case (state_q)
            LD_EMPTY: ;
            LD_HALF:  ;
            LD_PEND: begin
                copy_o  = tick_ok;
                armed_o = 1'b1;
            end
            LD_RUN: begin
                dec_o   = tick_ok;
                armed_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign clr_o       = wr_i;
    assign start_val_o = {hi_q, lo_q};

    // R2: the second byte completes the load
    a_r2_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_HALF && wr_i) |=> (state_q == LD_PEND));

    // R6: no copy or decrement while half loaded
    a_r6_half_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_HALF) |-> (!copy_o && !dec_o));
endmodule

// File: rtl/dlyt_counter.sv
module dlyt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             copy_i,
    input  logic             dec_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] start_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (copy_i) cnt_q <= start_val_i;
        else if (dec_i)  cnt_q <= cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      done_q <= 1'b0;
        else if (clr_i)                  done_q <= 1'b0;
        else if (dec_i && cnt_q == ONE)  done_q <= 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign done_o = done_q;

    // R4: done holds until a new write
    a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr_i) |=> done_q);

    // R6 / R7: counter stable when neither copy nor decrement is requested
    a_r6_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy_i && !dec_i) |=> $stable(cnt_q));

    // R5: a write drops done
    a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !done_q);
endmodule

// File: rtl/dlyt_readback.sv
module dlyt_readback #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              latch_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    logic [CNT_W-1:0] snap_q;
    logic held_q, ptr_hi_q;
    logic release_w;
    logic [CNT_W-1:0] view;

    assign release_w = rd_i & ptr_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            held_q <= 1'b0;
        end else if (release_w) begin
            held_q <= 1'b0;
        end else if (latch_i && !held_q) begin
            snap_q <= cnt_i;
            held_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr_hi_q <= 1'b0;
        else if (rd_i) ptr_hi_q <= ~ptr_hi_q;
    end

    assign view      = held_q ? snap_q : cnt_i;
    assign rd_data_o = ptr_hi_q ? view[CNT_W-1:BYTE_W] : view[BYTE_W-1:0];

    // R9: held copy does not move until released
    a_r9_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !release_w) |=> (held_q && $stable(snap_q)));

    // R9: high-byte read releases the copy
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        release_w |=> !held_q);
endmodule

// File: rtl/dlyt_top.sv
module dlyt_top #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              latch_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              done_o
);
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] cnt;
    logic copy, dec, clr, armed;

    dlyt_load_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_i),
        .wr_data_i   (wr_data_i),
        .tick_i      (tick_i),
        .start_val_o (start_val),
        .copy_o      (copy),
        .dec_o       (dec),
        .clr_o       (clr),
        .armed_o     (armed)
    );

    dlyt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .copy_i      (copy),
        .dec_i       (dec),
        .clr_i       (clr),
        .start_val_i (start_val),
        .cnt_o       (cnt),
        .done_o      (done_o)
    );

    dlyt_readback #(.BYTE_W(BYTE_W)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt),
        .latch_i   (latch_i),
        .rd_i      (rd_i),
        .rd_data_o (rd_data_o)
    );

    // R1: done never high without a completed load
    a_r1_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !done_o);

    // R10: a write in the same cycle blocks the strobe
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && tick_i) |=> $stable(cnt));
endmodule

// File: tb/dlyt_top_tb.sv
module dlyt_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [15:0] VEC_N [NVEC] = '{16'd1, 16'd2, 16'd3, 16'd7, 16'd16, 16'd257};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, wr = 1'b0, latch = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic done;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dlyt_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_i(wr), .wr_data_i(wdata),
        .latch_i(latch), .rd_i(rd), .rd_data_o(rdata), .done_o(done)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic with_tick);
        @(negedge clk);
        wr = 1'b1; wdata = b; tick = with_tick;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr_byte(v[7:0], 1'b0);
        wr_byte(v[15:8], 1'b0);
    endtask

    task automatic strobes(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk);
        rd = 1'b1;
        #1 b = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] w);
        logic [7:0] lo, hi;
        rd_byte(lo);
        rd_byte(hi);
        w = {hi, lo};
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [15:0] w;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 done after reset", {15'd0, done}, 16'd0);
        rd_word(w);
        check("R1 readback after reset", w, 16'h0000);

        // R7: strobes with nothing loaded
        strobes(5);
        rd_word(w);
        check("R7 counter untouched", w, 16'h0000);
        check("R7 done low", {15'd0, done}, 16'd0);

        // R2/R3: vector table
        for (int i = 0; i < NVEC; i++) begin
            load(VEC_N[i]);
            strobes(int'(VEC_N[i]));
            check("R3 done low one strobe early", {15'd0, done}, 16'd0);
            strobes(1);
            check("R3 done high after N+1 strobes", {15'd0, done}, 16'd1);
        end

        // R2: copy strobe does not decrement
        load(16'd10);
        strobes(1);
        rd_word(w);
        check("R2 copied value", w, 16'd10);

        // R6: freeze between bytes
        strobes(3);
        wr_byte(8'd4, 1'b0);
        strobes(5);
        rd_word(w);
        check("R6 frozen counter", w, 16'd7);
        check("R6 done low while half loaded", {15'd0, done}, 16'd0);
        wr_byte(8'd0, 1'b0);
        strobes(4);
        check("R5 new count not yet done", {15'd0, done}, 16'd0);
        strobes(1);
        check("R5 new count done", {15'd0, done}, 16'd1);

        // R5: full reload mid-count aborts
        load(16'd10);
        strobes(4);
        load(16'd2);
        check("R5 reload clears done", {15'd0, done}, 16'd0);
        strobes(2);
        check("R5 aborted count early", {15'd0, done}, 16'd0);
        strobes(1);
        check("R5 aborted count done", {15'd0, done}, 16'd1);

        // R4: wrap after done
        strobes(1);
        rd_word(w);
        check("R4 wrap to ffff", w, 16'hFFFF);
        check("R4 done stays high", {15'd0, done}, 16'd1);

        // R10: write collides with strobe
        wr_byte(8'd6, 1'b1);
        rd_word(w);
        check("R10 strobe ignored during write", w, 16'hFFFF);
        wr_byte(8'd0, 1'b0);
        strobes(6);
        check("R10 reload not done early", {15'd0, done}, 16'd0);
        strobes(1);
        check("R10 reload done", {15'd0, done}, 16'd1);

        // R9: latch and release
        load(16'd100);
        strobes(11);
        @(negedge clk); latch = 1'b1;
        @(negedge clk); latch = 1'b0;
        strobes(5);
        @(negedge clk); latch = 1'b1;
        @(negedge clk); latch = 1'b0;
        rd_byte(b);
        check("R9 latched low byte", {8'd0, b}, 16'd90);
        strobes(2);
        rd_byte(b);
        check("R9 latched high byte", {8'd0, b}, 16'd0);
        rd_word(w);
        check("R9 follows counter after release", w, 16'd83);

        // R8: zero count
        load(16'd0);
        strobes(65536);
        check("R8 zero not done at 65536", {15'd0, done}, 16'd0);
        strobes(1);
        check("R8 zero done at 65537", {15'd0, done}, 16'd1);

        finish_run();
    end
endmodule